// File: doc/BRIEF.md
# Predicate-Mask Element Skip Unit

This block sits at the front of a vectorised instruction's element loop. It holds two identical search engines, one for the source side and one for the destination side. When a start strobe arrives, each engine takes the side's current element step, the vector length (VL), the side's sub-element step and its zeroing-mode bit. It then reports the element step to execute next, together with a flag that says whether that element must be written as zero. A small mask selector ahead of the engines picks the predicate for each side. With predication off, every element is active. With predication on, the destination predicate drives the destination side. The source side follows the destination predicate unless the operation is twin-predicated, in which case it uses its own source predicate.

Masked-out elements are skipped only at the start of a sub-element group and only when zeroing is off. The engine walks one mask position per cycle until it reaches an active element or VL. A returned step equal to VL tells the sequencer that the instruction has no work left. In zeroing mode the step is never moved, and the zero flag marks an inactive element instead. Each side raises its own one-cycle done pulse, so the two sides can finish in different cycles.

Top module: `predicate_skip_unit`

## Requirements
- R1: With `pred_en_i` low, both sides treat every mask bit as 1. Every start then returns the incoming step unchanged, one cycle after the start edge, with the zero flag low.
- R2: With `pred_en_i` high, the destination side uses `dst_mask_i`. The source side uses `src_mask_i` when `twin_i` is high and `dst_mask_i` when it is low. Mask bit i belongs to element i.
- R3: A side searches only when its sub-element step is 0 and its zeroing bit is low. Otherwise it returns the incoming step unchanged, one cycle after start.
- R4: When searching from step s below VL, the result is the lowest step e with s <= e < VL whose mask bit is 1. Done rises 1 + (e - s) cycles after the start edge.
- R5: If no mask bit in [s, VL) is 1, the result is VL and the zero flag is low. Done rises 1 + (VL - s) cycles after start.
- R6: With zeroing on and step s below VL, the step is returned unchanged after one cycle, and the zero flag equals the inverse of the mask bit at s.
- R7: The sub-element step given at start is returned unchanged with the result.
- R8: An incoming step at or above VL is returned unchanged after one cycle, with the zero flag low, in every mode.
- R9: Positions of 64 or more read as inactive mask bits. With VL = 64 and an empty mask, a search from 0 ends at 64.
- R10: Each accepted start produces exactly one done pulse on that side. A start that arrives while that side is still searching is ignored by that side. No done pulse appears without a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search on both idle sides |
| pred_en_i | input | 1 | Predication active |
| twin_i | input | 1 | Source side uses its own predicate |
| dst_mask_i | input | 64 | Destination predicate, bit i = element i |
| src_mask_i | input | 64 | Source predicate for twin predication |
| vl_i | input | 7 | Vector length, 0 to 64 |
| src_step_i | input | 7 | Current source element step |
| dst_step_i | input | 7 | Current destination element step |
| src_sub_i | input | 2 | Source sub-element step |
| dst_sub_i | input | 2 | Destination sub-element step |
| src_zmode_i | input | 1 | Source zeroing mode |
| dst_zmode_i | input | 1 | Destination zeroing mode |
| src_done_o | output | 1 | Source result valid, one-cycle pulse |
| src_step_o | output | 7 | Next active source step, VL means finished |
| src_sub_o | output | 2 | Source sub-element step, passed through |
| src_zero_o | output | 1 | Source element must be zeroed |
| dst_done_o | output | 1 | Destination result valid, one-cycle pulse |
| dst_step_o | output | 7 | Next active destination step, VL means finished |
| dst_sub_o | output | 2 | Destination sub-element step, passed through |
| dst_zero_o | output | 1 | Destination element must be zeroed |

## Verification
A corrupted search position or a wrong stop test shows at the ports on the very next done pulse. The pulse then either carries the wrong step or arrives a different number of cycles after start, so the bench checks both the value and the exact latency of every result. A busy flag stuck high shows as a missing done pulse, and one stuck low shows as a surplus pulse or a start that was not ignored. The scoreboard catches either case no later than the next expected result.

// File: rtl/psk_pkg.sv
package psk_pkg;
  localparam int unsigned N_ELEM_DEF = 64;
  localparam int unsigned SUB_W_DEF  = 2;
  localparam int unsigned N_SIDES    = 2;

  typedef enum logic {
    SIDE_SRC = 1'b0,
    SIDE_DST = 1'b1
  } side_e;
endpackage

// File: rtl/psk_mask_sel.sv
module psk_mask_sel #(
  parameter int unsigned N_ELEM = psk_pkg::N_ELEM_DEF
) (
  input  logic              pred_en_i,
  input  logic              twin_i,
  input  logic [N_ELEM-1:0] dst_mask_i,
  input  logic [N_ELEM-1:0] src_mask_i,
  output logic [N_ELEM-1:0] src_eff_o,
  output logic [N_ELEM-1:0] dst_eff_o
);
  always_comb begin
    if (!pred_en_i) begin
      src_eff_o = '1;
      dst_eff_o = '1;
    end else begin
      dst_eff_o = dst_mask_i;
      src_eff_o = twin_i ? src_mask_i : dst_mask_i;
    end
  end
endmodule

// File: rtl/psk_engine.sv
module psk_engine #(
  parameter int unsigned N_ELEM = psk_pkg::N_ELEM_DEF,
  parameter int unsigned SUB_W  = psk_pkg::SUB_W_DEF,
  localparam int unsigned IDX_W  = $clog2(N_ELEM),
  localparam int unsigned STEP_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [N_ELEM-1:0] mask_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [SUB_W-1:0]  sub_i,
  input  logic              zmode_i,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              zero_o
);
  // positions beyond the mask read as inactive
  function automatic logic mask_bit(input logic [N_ELEM-1:0] m, input logic [STEP_W-1:0] pos);
    if (pos < STEP_W'(N_ELEM)) return m[pos[IDX_W-1:0]];
    return 1'b0;
  endfunction

  logic              busy_q, done_q, zmode_q, zero_q;
  logic [STEP_W-1:0] cur_q, vl_q, step_q;
  logic [N_ELEM-1:0] mask_q;
  logic [SUB_W-1:0]  sub_q;

  logic in_bit, in_live, skip_en, cur_stop;

  always_comb begin
    in_bit   = mask_bit(mask_i, step_i);
    in_live  = step_i < vl_i;
    skip_en  = (sub_i == '0) && !zmode_i;
    cur_stop = mask_bit(mask_q, cur_q) || (cur_q >= vl_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      zmode_q <= 1'b0;
      zero_q  <= 1'b0;
      cur_q   <= '0;
      vl_q    <= '0;
      step_q  <= '0;
      mask_q  <= '0;
      sub_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          sub_q   <= sub_i;
          vl_q    <= vl_i;
          mask_q  <= mask_i;
          zmode_q <= zmode_i;
          if (skip_en && in_live && !in_bit) begin
            busy_q <= 1'b1;
            cur_q  <= step_i + 1'b1;
          end else begin
            done_q <= 1'b1;
            step_q <= step_i;
            zero_q <= zmode_i && in_live && !in_bit;
          end
        end
      end else if (cur_stop) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        step_q <= cur_q;
        zero_q <= 1'b0;
      end else begin
        cur_q <= cur_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign step_o = step_q;
  assign sub_o  = sub_q;
  assign zero_o = zero_q;

  p_search_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cur_q <= vl_q);
  p_zero_no_search_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !zmode_q);
  p_land_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cur_stop |=> done_o && (step_o == vl_q || mask_bit(mask_q, step_o)));
  p_zero_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && zero_o |-> zmode_q && step_o < vl_q && !mask_bit(mask_q, step_o));
  p_no_spurious_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !start_i |=> !done_o);
  p_no_done_while_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !cur_stop |=> !done_o && busy_q);
endmodule

// File: rtl/predicate_skip_unit.sv
module predicate_skip_unit #(
  parameter int unsigned N_ELEM = psk_pkg::N_ELEM_DEF,
  parameter int unsigned SUB_W  = psk_pkg::SUB_W_DEF,
  localparam int unsigned STEP_W = $clog2(N_ELEM) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              pred_en_i,
  input  logic              twin_i,
  input  logic [N_ELEM-1:0] dst_mask_i,
  input  logic [N_ELEM-1:0] src_mask_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [STEP_W-1:0] src_step_i,
  input  logic [STEP_W-1:0] dst_step_i,
  input  logic [SUB_W-1:0]  src_sub_i,
  input  logic [SUB_W-1:0]  dst_sub_i,
  input  logic              src_zmode_i,
  input  logic              dst_zmode_i,
  output logic              src_done_o,
  output logic [STEP_W-1:0] src_step_o,
  output logic [SUB_W-1:0]  src_sub_o,
  output logic              src_zero_o,
  output logic              dst_done_o,
  output logic [STEP_W-1:0] dst_step_o,
  output logic [SUB_W-1:0]  dst_sub_o,
  output logic              dst_zero_o
);
  import psk_pkg::*;

  logic [N_SIDES-1:0][N_ELEM-1:0] eff_mask;
  logic [N_SIDES-1:0][STEP_W-1:0] step_in, step_out;
  logic [N_SIDES-1:0][SUB_W-1:0]  sub_in, sub_out;
  logic [N_SIDES-1:0]             zm_in, done_out, zero_out;

  psk_mask_sel #(.N_ELEM(N_ELEM)) i_mask_sel (
    .pred_en_i (pred_en_i),
    .twin_i    (twin_i),
    .dst_mask_i(dst_mask_i),
    .src_mask_i(src_mask_i),
    .src_eff_o (eff_mask[SIDE_SRC]),
    .dst_eff_o (eff_mask[SIDE_DST])
  );

  assign step_in[SIDE_SRC] = src_step_i;
  assign step_in[SIDE_DST] = dst_step_i;
  assign sub_in[SIDE_SRC]  = src_sub_i;
  assign sub_in[SIDE_DST]  = dst_sub_i;
  assign zm_in[SIDE_SRC]   = src_zmode_i;
  assign zm_in[SIDE_DST]   = dst_zmode_i;

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    psk_engine #(.N_ELEM(N_ELEM), .SUB_W(SUB_W)) i_engine (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .mask_i (eff_mask[g]),
      .vl_i   (vl_i),
      .step_i (step_in[g]),
      .sub_i  (sub_in[g]),
      .zmode_i(zm_in[g]),
      .done_o (done_out[g]),
      .step_o (step_out[g]),
      .sub_o  (sub_out[g]),
      .zero_o (zero_out[g])
    );
  end

  assign src_done_o = done_out[SIDE_SRC];
  assign src_step_o = step_out[SIDE_SRC];
  assign src_sub_o  = sub_out[SIDE_SRC];
  assign src_zero_o = zero_out[SIDE_SRC];
  assign dst_done_o = done_out[SIDE_DST];
  assign dst_step_o = step_out[SIDE_DST];
  assign dst_sub_o  = sub_out[SIDE_DST];
  assign dst_zero_o = zero_out[SIDE_DST];
endmodule

// File: tb/test_predicate_skip_unit.sv
`timescale 1ns/1ps
module test_predicate_skip_unit;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic        pred_en_i = 1'b0, twin_i = 1'b0;
  logic [63:0] dst_mask_i = '0, src_mask_i = '0;
  logic [6:0]  vl_i = '0, src_step_i = '0, dst_step_i = '0;
  logic [1:0]  src_sub_i = '0, dst_sub_i = '0;
  logic        src_zmode_i = 1'b0, dst_zmode_i = 1'b0;
  logic        src_done_o, src_zero_o, dst_done_o, dst_zero_o;
  logic [6:0]  src_step_o, dst_step_o;
  logic [1:0]  src_sub_o, dst_sub_o;

  predicate_skip_unit i_predicate_skip_unit (.*);

  always #2 clk_i = ~clk_i;

  typedef struct {
    int    step;
    int    sub;
    bit    zero;
    int    due;
    string req;
  } exp_t;

  exp_t src_q[$], dst_q[$];
  int checks = 0, errors = 0, cyc = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic bit mbit(logic [63:0] m, int pos);
    return (pos < 64) ? m[pos] : 1'b0;
  endfunction

  function automatic exp_t model(logic [63:0] m, int vl, int s, int sub, bit zm, int t0, string req);
    exp_t e;
    int r = s;
    e.sub = sub; e.req = req; e.zero = 0;
    if (s < vl && sub == 0 && !zm)
      while (r < vl && !mbit(m, r)) r++;
    if (s < vl && zm) e.zero = !mbit(m, s);
    e.step = r;
    e.due  = t0 + 1 + (r - s);
    return e;
  endfunction

  task automatic chk(string side, exp_t e, int st, int sb, bit z);
    checks++;
    if (st != e.step || sb != e.sub || z != e.zero || cyc != e.due) begin
      errors++;
      $display("FAIL %s %s: step=%0d sub=%0d zero=%0d cyc=%0d expected step=%0d sub=%0d zero=%0d cyc=%0d",
               e.req, side, st, sb, z, cyc, e.step, e.sub, e.zero, e.due);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && src_done_o) begin
      if (src_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 src: done=1 expected no pulse");
      end else chk("src", src_q.pop_front(), src_step_o, src_sub_o, src_zero_o);
    end
    if (rst_ni && dst_done_o) begin
      if (dst_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 dst: done=1 expected no pulse");
      end else chk("dst", dst_q.pop_front(), dst_step_o, dst_sub_o, dst_zero_o);
    end
  end

  // driver: call at a negedge
  task automatic go(bit pe, bit tw, logic [63:0] dm, logic [63:0] sm, int vl,
                    int ss, int ds, int ssub, int dsub, bit szm, bit dzm,
                    string req, bit push_src = 1, bit push_dst = 1, bit wait_done = 1);
    logic [63:0] se, de;
    pred_en_i = pe; twin_i = tw; dst_mask_i = dm; src_mask_i = sm; vl_i = 7'(vl);
    src_step_i = 7'(ss); dst_step_i = 7'(ds); src_sub_i = 2'(ssub); dst_sub_i = 2'(dsub);
    src_zmode_i = szm; dst_zmode_i = dzm;
    de = pe ? dm : '1;
    se = !pe ? '1 : (tw ? sm : dm);
    if (push_src) src_q.push_back(model(se, vl, ss, ssub, szm, cyc, req));
    if (push_dst) dst_q.push_back(model(de, vl, ds, dsub, dzm, cyc, req));
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (wait_done) begin
      while (src_q.size() != 0 || dst_q.size() != 0) @(negedge clk_i);
      @(negedge clk_i);
    end
  endtask

  initial begin
    logic [63:0] lf = 64'h9e37_79b9_7f4a_7c15;
    repeat (3) @(negedge clk_i);
    checks++;
    if (src_done_o || dst_done_o || src_step_o != 0 || dst_step_o != 0 || src_zero_o || dst_zero_o) begin
      errors++;
      $display("FAIL R10 reset: done=%b%b step=%0d/%0d zero=%b%b expected all zero",
               src_done_o, dst_done_o, src_step_o, dst_step_o, src_zero_o, dst_zero_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    go(0, 0, '0, '0, 10, 3, 5, 0, 0, 0, 0, "R1");
    go(0, 1, '0, '0, 64, 63, 0, 0, 0, 0, 0, "R1");
    go(1, 0, 64'h80, 64'h1, 10, 2, 0, 0, 0, 0, 0, "R4");
    go(1, 1, 64'h200, 64'h10, 12, 0, 0, 0, 0, 0, 0, "R2");
    go(1, 0, 64'h200, 64'h10, 12, 0, 1, 0, 0, 0, 0, "R2");
    go(1, 0, 64'h0, 64'h0, 10, 4, 4, 1, 3, 0, 0, "R3");
    go(1, 0, 64'h40, 64'h0, 6, 0, 2, 0, 0, 0, 0, "R5");
    go(1, 1, 64'h5, 64'hA, 8, 1, 0, 0, 2, 1, 1, "R6");
    go(1, 1, 64'h5, 64'hA, 8, 0, 1, 1, 0, 1, 1, "R6");
    go(1, 0, 64'h3, 64'h0, 6, 3, 1, 2, 3, 0, 1, "R7");
    go(1, 0, 64'h0, 64'h0, 10, 12, 10, 0, 0, 1, 0, "R8");
    go(0, 0, 64'h0, 64'h0, 0, 0, 127, 2, 0, 0, 1, "R8");
    go(1, 0, 64'h0, 64'h0, 64, 0, 60, 0, 0, 0, 0, "R9");
    go(1, 1, 64'h8000_0000_0000_0000, 64'h0, 64, 1, 62, 0, 0, 0, 0, "R9");

    // R10: second start lands while source still searching
    go(1, 1, 64'h1, 64'h0, 40, 0, 0, 0, 0, 0, 0, "R10", 1, 1, 0);
    @(negedge clk_i);
    go(1, 1, 64'hFF, 64'hFF, 40, 5, 3, 0, 0, 0, 0, "R10", 0, 1, 1);
    repeat (5) @(negedge clk_i);

    for (int i = 0; i < 12; i++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      go(1, lf[0], lf & {lf[31:0], lf[63:32]}, ~lf, 8 + int'(lf[5:0] % 57),
         int'(lf[10:6]), int'(lf[16:12]), 0, int'(lf[1]), 0, lf[2], "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R10 watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule